// File: doc/BRIEF.md
# Serial Command Input Port

This block takes a 64-bit command word that an external computer shifts in one bit at a time and hands it to a local processor through a single ready flag. The computer's side has three asynchronous lines: serial data, a free-running clock and an active-low load pulse. The processor's side has a ready flag, a one-cycle "finished read" strobe and a one-cycle read strobe. Each read strobe moves the stored word one place toward a serial output.

All three external lines pass through two-flop synchronisers, and the external clock is edge-detected in the system clock domain. A shift is accepted only when the ready flag is low and the load line is inactive. When the load pulse arrives, the register is frozen and the ready flag goes high. While the flag is high, external clocks have no effect. The path opens again only when the processor issues its finished-read strobe. The five top bits of the word carry the destination file selector, and the block shows them in parallel while the word is ready. A frame that is closed by a load pulse before all 64 bits have arrived is still presented as it stands, and a sticky flag marks it as short.

The external clock high and low phases must each last at least four system clocks. Data must be stable for at least two system clocks before the rising clock edge.

Top module: `cmd_serial_port`

## Requirements
- R1: After reset, `data_ready` is 0, `short_frame` is 0, `file_sel` is 0 and the register is all zeros, so `rd_data` is 0.
- R2: While `data_ready` is 0 and `ext_load_n` is high, each rising edge of `ext_clk` shifts `ext_data` into bit 63 and moves the register one place toward bit 0. After 64 edges, the first bit sent sits in bit 0 and the last in bit 63.
- R3: A falling edge on `ext_load_n` while `data_ready` is 0 sets `data_ready` to 1.
- R4: While `data_ready` is 1, edges on `ext_clk` leave the stored word unchanged.
- R5: A `fin_rd` pulse clears `data_ready` and `short_frame` on the next clock and re-enables the external shift path.
- R6: While `data_ready` is 1, `rd_data` shows bit 0 of the register. Each `rd_strobe` pulse shifts the register one place toward bit 0 and fills bit 63 with 0, so 64 pulses deliver the word LSB first.
- R7: `rd_strobe` pulses while `data_ready` is 0 leave the register unchanged.
- R8: While `data_ready` is 1, `file_sel` equals register bits 63..59. Bit 63 is the bank bit, and bits 62..59 are the four-bit file code. While `data_ready` is 0, `file_sel` is 0.
- R9: A load that closes a frame with fewer than 64 accepted bits since the previous load or reset sets `short_frame`. A load after 64 or more bits leaves it at 0.
- R10: A falling edge on `ext_load_n` while `data_ready` is 1 is ignored: `data_ready` stays 1 and `short_frame` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External serial clock, asynchronous |
| ext_data | input | 1 | External serial data, asynchronous |
| ext_load_n | input | 1 | External active-low end-of-frame pulse, asynchronous |
| fin_rd | input | 1 | Processor finished-read strobe, one cycle |
| rd_strobe | input | 1 | Processor read-shift strobe, one cycle |
| data_ready | output | 1 | A frame is held and awaiting the processor |
| rd_data | output | 1 | Serial read data, bit 0 of the register |
| file_sel | output | 5 | Bank bit and file code while ready, else 0 |
| short_frame | output | 1 | Sticky flag: last frame had fewer than 64 bits |

## Verification
Random 64-bit frames check shift order and LSB-first readout. They would expose a reversed shift direction or a bit that gets lost. On some frames, extra external clocks with random data and a second load pulse are applied after the frame is ready. These show whether the input path is really closed and whether the short flag is disturbed. Short frames of random length, and frames with zero bits, check the short flag and the presentation of partial contents. Read strobes issued while the flag is low, between partial reads, check that the readout path is gated by the ready flag.

// File: rtl/cmd_serial_port.sv
module cmd_serial_port #(
  parameter int WIDTH = 64,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             ext_data,
  input  logic             ext_load_n,
  input  logic             fin_rd,
  input  logic             rd_strobe,
  output logic             data_ready,
  output logic             rd_data,
  output logic [SEL_W-1:0] file_sel,
  output logic             short_frame
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [2:0]       ck_s;
  logic [1:0]       d_s;
  logic [2:0]       ld_s;
  logic [WIDTH-1:0] sr;
  logic [CW-1:0]    cnt;

  wire ck_rise  = ck_s[1] & ~ck_s[2];
  wire ld_fall  = ~ld_s[1] & ld_s[2];
  wire ld_act   = ~ld_s[1];
  wire shift_in = ck_rise & ~data_ready & ~ld_act;
  wire shift_rd = rd_strobe & data_ready & ~fin_rd;
  wire take_ld  = ld_fall & ~data_ready & ~fin_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      d_s  <= '0;
      ld_s <= '1;
    end else begin
      ck_s <= {ck_s[1:0], ext_clk};
      d_s  <= {d_s[0], ext_data};
      ld_s <= {ld_s[1:0], ext_load_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (shift_in) begin
      sr <= {d_s[1], sr[WIDTH-1:1]};
    end else if (shift_rd) begin
      sr <= {1'b0, sr[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (take_ld) begin
      cnt <= '0;
    end else if (shift_in && cnt != CW'(WIDTH)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ready  <= 1'b0;
      short_frame <= 1'b0;
    end else if (fin_rd) begin
      data_ready  <= 1'b0;
      short_frame <= 1'b0;
    end else if (take_ld) begin
      data_ready  <= 1'b1;
      short_frame <= (cnt != CW'(WIDTH));
    end
  end

  assign rd_data  = sr[0];
  assign file_sel = data_ready ? sr[WIDTH-1 -: SEL_W] : '0;
endmodule

// File: rtl/cmd_serial_port_chk.sv
module cmd_serial_port_chk #(
  parameter int WIDTH = 64,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fin_rd,
  input logic             rd_strobe,
  input logic             data_ready,
  input logic             short_frame,
  input logic             rd_data,
  input logic [SEL_W-1:0] file_sel,
  input logic [WIDTH-1:0] sr,
  input logic [2:0]       ld_s
);
  a_r3_load_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_s[1] && ld_s[2] && !data_ready && !fin_rd) |=> data_ready);

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !rd_strobe && !fin_rd) |=> $stable(sr));

  a_r5_fin_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fin_rd |=> (!data_ready && !short_frame));

  a_r6_read_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_strobe && !fin_rd) |=> (rd_data == $past(sr[1]) && !sr[WIDTH-1]));

  a_r8_sel_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> (file_sel == '0));

  a_r9_short_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |-> data_ready);

  a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !fin_rd) |=> data_ready);
endmodule

bind cmd_serial_port cmd_serial_port_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fin_rd(fin_rd), .rd_strobe(rd_strobe),
  .data_ready(data_ready), .short_frame(short_frame), .rd_data(rd_data),
  .file_sel(file_sel), .sr(sr), .ld_s(ld_s)
);

// File: tb/tb_cmd_serial_port.sv
module tb_cmd_serial_port;
  logic clk = 0, rst_n = 0;
  logic ext_clk = 0, ext_data = 0, ext_load_n = 1, fin_rd = 0, rd_strobe = 0;
  logic data_ready, rd_data, short_frame;
  logic [4:0] file_sel;

  int checks = 0, failures = 0;
  logic [63:0] m = '0;
  int mc = 0;
  bit mready = 0, mshort = 0;

  always #10 clk = ~clk;

  cmd_serial_port dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_data(ext_data),
    .ext_load_n(ext_load_n), .fin_rd(fin_rd), .rd_strobe(rd_strobe),
    .data_ready(data_ready), .rd_data(rd_data), .file_sel(file_sel),
    .short_frame(short_frame)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    ext_data = b;
    repeat (3) @(negedge clk);
    ext_clk = 1;
    repeat (4) @(negedge clk);
    ext_clk = 0;
    repeat (4) @(negedge clk);
    if (!mready) begin
      m = {b, m[63:1]};
      if (mc < 64) mc++;
    end
  endtask

  task automatic pulse_load();
    ext_load_n = 0;
    repeat (5) @(negedge clk);
    ext_load_n = 1;
    repeat (5) @(negedge clk);
    if (!mready) begin
      mready = 1;
      mshort = (mc < 64);
      mc = 0;
    end
  endtask

  task automatic do_fin();
    fin_rd = 1;
    @(negedge clk);
    fin_rd = 0;
    @(negedge clk);
    mready = 0;
    mshort = 0;
  endtask

  task automatic read_bit(output bit b);
    b = rd_data;
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    @(negedge clk);
    if (mready) m = {1'b0, m[63:1]};
  endtask

  task automatic read_word(output logic [63:0] w);
    for (int i = 0; i < 64; i++) begin
      bit b;
      read_bit(b);
      w[i] = b;
    end
  endtask

  function automatic logic [4:0] sel_of(input logic [63:0] w);
    return w[63:59];
  endfunction

  task automatic check_ready_state(input string tag);
    chk(data_ready == mready, {tag, " R3 data_ready"}, 64'(data_ready), 64'(mready));
    chk(short_frame == mshort, {tag, " R9 short_frame"}, 64'(short_frame), 64'(mshort));
    chk(file_sel == (mready ? sel_of(m) : 5'd0), {tag, " R8 file_sel"},
        64'(file_sel), 64'(mready ? sel_of(m) : 5'd0));
  endtask

  initial begin
    #(20ns * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] frame, w, exp;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!data_ready, "R1 data_ready", 64'(data_ready), 0);
    chk(!short_frame, "R1 short_frame", 64'(short_frame), 0);
    chk(file_sel == 0, "R1 file_sel", 64'(file_sel), 0);
    chk(!rd_data, "R1 rd_data", 64'(rd_data), 0);

    // R7 reads while not ready, then zero-bit frame exposes contents
    for (int i = 0; i < 3; i++) begin bit b; read_bit(b); end
    pulse_load();
    check_ready_state("zero-bit");
    read_word(w);
    chk(w == 64'd0, "R7 reset contents kept", w, 64'd0);
    do_fin();

    for (int f = 0; f < 14; f++) begin
      case (f)
        0: frame = 64'h8000_0000_0000_0001;
        1: frame = '1;
        2: frame = 64'h7800_0000_0000_0000;
        default: frame = {$urandom, $urandom};
      endcase
      for (int i = 0; i < 64; i++) send_bit(frame[i]);
      pulse_load();
      // R2, R3, R8, R9
      check_ready_state("full");
      chk(file_sel == frame[63:59], "R8 file_sel from frame", 64'(file_sel), 64'(frame[63:59]));
      chk(short_frame == 0, "R9 full frame not short", 64'(short_frame), 0);
      if (f % 2 == 1) begin
        for (int i = 0; i < 5; i++) send_bit(1'($urandom));
        pulse_load();
        // R10 second load ignored
        chk(data_ready == 1, "R10 ready held", 64'(data_ready), 1);
        chk(short_frame == 0, "R10 short unchanged", 64'(short_frame), 0);
      end
      read_word(w);
      // R2 order, R4 frozen, R6 LSB-first readout
      chk(w == frame, "R6 R4 R2 readout", w, frame);
      chk(rd_data == 0, "R6 zero fill", 64'(rd_data), 0);
      do_fin();
      // R5
      chk(!data_ready && !short_frame, "R5 fin clears", {data_ready, short_frame}, 0);
      chk(file_sel == 0, "R8 sel gated", 64'(file_sel), 0);
    end

    // R9 short frames of random length
    for (int s = 0; s < 4; s++) begin
      int n;
      n = 1 + ($urandom % 40);
      for (int i = 0; i < n; i++) send_bit(1'($urandom));
      exp = m;
      pulse_load();
      check_ready_state("short");
      chk(short_frame == 1, "R9 short flag", 64'(short_frame), 1);
      // partial reads, fin, then ignored reads (R7)
      for (int i = 0; i < 5; i++) begin bit b; read_bit(b); chk(b == exp[i], "R6 partial read", 64'(b), 64'(exp[i])); end
      do_fin();
      chk(short_frame == 0, "R5 short cleared", 64'(short_frame), 0);
      exp = m;
      for (int i = 0; i < 4; i++) begin bit b; read_bit(b); end
      pulse_load();
      read_word(w);
      chk(w == exp, "R7 reads ignored while not ready", w, exp);
      do_fin();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule